// File: doc/BRIEF.md
# SPI Target Buffer-Backed Byte Queues

This block is the byte data path of an SPI target operating in its plain byte-stream mode. A byte-level shift stage, which is not part of this block, presents each received serial byte. The block stores that byte in a receive window of a shared buffer memory. When the shift stage asks for the next outgoing byte, the block supplies it from a transmit window of the same memory. Each window is a circular queue. Software places each window with a base/limit register and drives the software side of each queue through a pointer register. On the receive queue software owns the read pointer. On the transmit queue software owns the write pointer.

The block reports both queue levels. It raises sticky event flags for: receive queue full, receive level passing a watermark, transmit level falling under a watermark, a receive byte dropped on overflow, and a transmit request made while the queue is empty. The interrupt outputs are those flags masked by an enable register. A control write can clear either queue. Software reaches the registers through a simple word register port and the buffer through a byte port.

Top module: `spi_buf_fifo`

## Requirements
- R1: After reset the receive window register (offset 7) reads base 0 / limit 508, the transmit window register (offset 8) reads base 512 / limit 1020, the watermark register (offset 3) reads 0x80 in bits 15:0 and 0 in bits 31:16, control (offset 0) reads 0, both levels read 0, and `irq` is 0.
- R2: A window register holds the base word index in bits 15:0 and the limit in bits 31:16. The window occupies byte addresses base×4 to (limit+4)×4−1. Queue addresses wrap from the last byte of the window back to its first byte.
- R3: Each accepted received byte is written at window start plus the write pointer offset, and the receive write pointer rises by one. The receive pointer register (offset 5) holds the read pointer in bits 15:0, which software writes, and the write pointer in bits 31:16. The level register (offset 4) shows write minus read pointer: receive in bits 15:0, transmit in bits 31:16.
- R4: While the transmit level is non-zero, `tx_byte` shows the buffer byte at the transmit read position. A `tx_req` pulse consumes that byte. The transmit pointer register (offset 6) holds the read pointer in bits 15:0 and the software-written write pointer in bits 31:16.
- R5: `rx_valid` and `tx_req` have no effect unless control bit 31 is 1 and control bits 7:4 are 0.
- R6: Writing control with bit 16 set clears both receive pointers. Writing control with bit 17 set clears both transmit pointers.
- R7: Flag bit 0 (receive full) sets when an accepted byte brings the receive level to the window size.
- R8: A received byte that arrives while the receive queue is full is dropped: the pointers and memory are unchanged and flag bit 4 sets.
- R9: Flag bit 1 sets when an accepted byte takes the receive level from the receive watermark to one above it, and not earlier.
- R10: Flag bit 2 sets when a consumed transmit byte leaves the level below the transmit watermark (bits 31:16 of offset 3).
- R11: Flag bit 5 sets when `tx_req` arrives while the transmit level is 0.
- R12: Flags in the state register (offset 1) are sticky and are cleared by writing 1 to them. `irq` equals the flags ANDed with the enable register (offset 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_addr | input | 12 | Buffer byte address |
| buf_wdata | input | 8 | Buffer write byte |
| buf_rdata | output | 8 | Buffer byte at `buf_addr` |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Shift stage consumes the next outgoing byte |
| tx_byte | output | 8 | Next outgoing byte |
| irq | output | 6 | Enabled event flags |

## Verification
If a pointer is corrupted, the level register shows a wrong value from the next cycle on. Every later outgoing byte is also taken from the wrong buffer position, so `tx_byte` is wrong for the rest of the stream. A wrong size or offset calculation shows up only at the window boundary: an early or late full flag, or a wrong byte after the wrap. The tests therefore fill the receive queue to its last byte and run the transmit queue through its wrap. A watermark comparison that is off by one moves the flag by exactly one byte, so each flag is sampled on the byte before its threshold and on the threshold byte itself.

// File: rtl/spi_buf_fifo.sv
module spi_buf_fifo #(
  parameter int BUF_WORDS = 1024,
  parameter logic [15:0] RX_BASE0 = 16'd0,
  parameter logic [15:0] RX_LIM0  = 16'd508,
  parameter logic [15:0] TX_BASE0 = 16'd512,
  parameter logic [15:0] TX_LIM0  = 16'd1020,
  parameter logic [15:0] RX_WM0   = 16'h0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        buf_we,
  input  logic [$clog2(BUF_WORDS*4)-1:0] buf_addr,
  input  logic [7:0]  buf_wdata,
  output logic [7:0]  buf_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        tx_req,
  output logic [7:0]  tx_byte,
  output logic [5:0]  irq
);
  localparam int BAW = $clog2(BUF_WORDS*4);

  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_IEN = 4'd2, A_WM = 4'd3,
                         A_LVL = 4'd4, A_RXP = 4'd5, A_TXP = 4'd6, A_RXW = 4'd7, A_TXW = 4'd8;

  logic [7:0]  mem [BUF_WORDS][4];
  logic [15:0] rx_base, rx_lim, tx_base, tx_lim, rx_wm, tx_wm;
  logic [15:0] rx_rptr, rx_wptr, tx_rptr, tx_wptr;
  logic        ctrl_en;
  logic [3:0]  ctrl_mode;
  logic [5:0]  int_st, int_en, ev, st_clr;

  function automatic logic [15:0] lvl_f(input logic [15:0] w, r, sz);
    return (w >= r) ? w - r : w + {sz[14:0], 1'b0} - r;
  endfunction

  function automatic logic [15:0] nxt_f(input logic [15:0] p, sz);
    return (p + 16'd1 == {sz[14:0], 1'b0}) ? 16'd0 : p + 16'd1;
  endfunction

  function automatic logic [BAW-1:0] addr_f(input logic [15:0] base, p, sz);
    logic [17:0] off;
    off = {2'b00, (p >= sz) ? p - sz : p};
    return BAW'({base, 2'b00} + off);
  endfunction

  wire [15:0] rx_size = 16'((rx_lim + 16'd4 - rx_base) << 2);
  wire [15:0] tx_size = 16'((tx_lim + 16'd4 - tx_base) << 2);
  wire [15:0] rx_lvl  = lvl_f(rx_wptr, rx_rptr, rx_size);
  wire [15:0] tx_lvl  = lvl_f(tx_wptr, tx_rptr, tx_size);

  wire active  = ctrl_en && (ctrl_mode == 4'd0);
  wire rx_push = rx_valid && active;
  wire rx_acc  = rx_push && (rx_lvl != rx_size);
  wire tx_ask  = tx_req && active;
  wire tx_pop  = tx_ask && (tx_lvl != 16'd0);
  wire ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  wire rx_clr  = ctrl_wr && reg_wdata[16];
  wire tx_clr  = ctrl_wr && reg_wdata[17];

  wire [BAW-1:0] rx_waddr = addr_f(rx_base, rx_wptr, rx_size);
  wire [BAW-1:0] tx_raddr = addr_f(tx_base, tx_rptr, tx_size);

  assign buf_rdata = mem[buf_addr[BAW-1:2]][buf_addr[1:0]];
  assign tx_byte   = mem[tx_raddr[BAW-1:2]][tx_raddr[1:0]];
  assign irq       = int_st & int_en;

  assign ev[0] = rx_acc && (rx_lvl + 16'd1 == rx_size);
  assign ev[1] = rx_acc && (rx_lvl == rx_wm);
  assign ev[2] = tx_pop && (tx_lvl <= tx_wm);
  assign ev[3] = 1'b0;
  assign ev[4] = rx_push && (rx_lvl == rx_size);
  assign ev[5] = tx_ask && (tx_lvl == 16'd0);
  assign st_clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[5:0] : 6'd0;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {ctrl_en, 23'd0, ctrl_mode, 4'd0};
      A_STAT:  reg_rdata = {26'd0, int_st};
      A_IEN:   reg_rdata = {26'd0, int_en};
      A_WM:    reg_rdata = {tx_wm, rx_wm};
      A_LVL:   reg_rdata = {tx_lvl, rx_lvl};
      A_RXP:   reg_rdata = {rx_wptr, rx_rptr};
      A_TXP:   reg_rdata = {tx_wptr, tx_rptr};
      A_RXW:   reg_rdata = {rx_lim, rx_base};
      A_TXW:   reg_rdata = {tx_lim, tx_base};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (buf_we) mem[buf_addr[BAW-1:2]][buf_addr[1:0]] <= buf_wdata;
    if (rx_acc) mem[rx_waddr[BAW-1:2]][rx_waddr[1:0]] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;   ctrl_mode <= 4'd0;
      int_st  <= 6'd0;   int_en    <= 6'd0;
      rx_base <= RX_BASE0; rx_lim <= RX_LIM0;
      tx_base <= TX_BASE0; tx_lim <= TX_LIM0;
      rx_wm   <= RX_WM0;  tx_wm   <= 16'd0;
      rx_rptr <= 16'd0;  rx_wptr <= 16'd0;
      tx_rptr <= 16'd0;  tx_wptr <= 16'd0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin ctrl_en <= reg_wdata[31]; ctrl_mode <= reg_wdata[7:4]; end
          A_IEN:  int_en <= reg_wdata[5:0];
          A_WM:   begin rx_wm <= reg_wdata[15:0]; tx_wm <= reg_wdata[31:16]; end
          A_RXP:  rx_rptr <= reg_wdata[15:0];
          A_TXP:  tx_wptr <= reg_wdata[31:16];
          A_RXW:  begin rx_base <= reg_wdata[15:0]; rx_lim <= reg_wdata[31:16]; end
          A_TXW:  begin tx_base <= reg_wdata[15:0]; tx_lim <= reg_wdata[31:16]; end
          default: ;
        endcase
      end
      if (rx_acc) rx_wptr <= nxt_f(rx_wptr, rx_size);
      if (tx_pop) tx_rptr <= nxt_f(tx_rptr, tx_size);
      if (rx_clr) begin rx_rptr <= 16'd0; rx_wptr <= 16'd0; end
      if (tx_clr) begin tx_rptr <= 16'd0; tx_wptr <= 16'd0; end
      int_st <= (int_st & ~st_clr) | ev;
    end
  end

  assert_rx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc && !reg_wr |=> rx_lvl == $past(rx_lvl) + 16'd1);
  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[16] |=> rx_lvl == 16'd0);
  assert_rx_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !reg_wr && (rx_lvl + 16'd1 == rx_size) |=> int_st[0]);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !reg_wr && (rx_lvl == rx_size) |=> $stable(rx_wptr) && int_st[4]);
  assert_tx_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ask && (tx_lvl == 16'd0) |=> int_st[5] && $stable(tx_rptr));
endmodule

// File: tb/tb_spi_buf_fifo.sv
module tb_spi_buf_fifo;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, buf_we = 0, rx_valid = 0, tx_req = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [11:0] buf_addr = 0;
  logic [7:0] buf_wdata = 0, buf_rdata, rx_byte = 0, tx_byte;
  logic [5:0] irq;
  int checks = 0, errors = 0;
  localparam logic [31:0] EN = 32'h8000_0000;

  always #5 clk = ~clk;

  spi_buf_fifo dut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .buf_we, .buf_addr, .buf_wdata, .buf_rdata, .rx_valid, .rx_byte, .tx_req, .tx_byte, .irq);

  task automatic step; @(posedge clk); @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step; reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic bw(input logic [11:0] a, input logic [7:0] d);
    buf_we = 1; buf_addr = a; buf_wdata = d; step; buf_we = 0;
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; step; rx_valid = 0;
  endtask

  task automatic pop(input string req, input logic [7:0] exp);
    chk(req, {24'd0, tx_byte}, {24'd0, exp});
    tx_req = 1; step; tx_req = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(7, d); chk("R1 rx window", d, {16'd508, 16'd0});
    rd(8, d); chk("R1 tx window", d, {16'd1020, 16'd512});
    rd(3, d); chk("R1 watermarks", d, 32'h0000_0080);
    rd(0, d); chk("R1 control", d, 0);
    rd(4, d); chk("R1 levels", d, 0);
    chk("R1 irq", {26'd0, irq}, 0);
  endtask

  task automatic t_gating;
    logic [31:0] d;
    send(8'h55); rd(5, d); chk("R5 disabled rx", d, 0);
    wr(0, EN | 32'h10); send(8'h55);
    tx_req = 1; step; tx_req = 0;
    rd(5, d); chk("R5 mode 1 rx", d, 0);
    rd(1, d); chk("R5 mode 1 tx no underflow", d, 0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    wr(0, EN);
    send(8'hde); send(8'had); send(8'hbe); send(8'hef);
    rd(5, d); chk("R3 rx write pointer", d, {16'd4, 16'd0});
    rd(4, d); chk("R3 rx level", d, 32'd4);
    buf_addr = 0; #1 chk("R3 byte0", {24'd0, buf_rdata}, 32'hde);
    buf_addr = 3; #1 chk("R3 byte3", {24'd0, buf_rdata}, 32'hef);
    wr(5, 32'd2); rd(4, d); chk("R3 level after read", d, 32'd2);
  endtask

  task automatic t_tx_basic;
    logic [31:0] d;
    bw(2048, 8'hde); bw(2049, 8'had); bw(2050, 8'hbe); bw(2051, 8'hef);
    wr(6, 32'd4 << 16);
    rd(4, d); chk("R4 tx level", d[31:16], 32'd4);
    pop("R4 tx byte0", 8'hde); pop("R4 tx byte1", 8'had);
    pop("R4 tx byte2", 8'hbe); pop("R4 tx byte3", 8'hef);
    rd(6, d); chk("R4 tx pointers", d, {16'd4, 16'd4});
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(0, EN | 32'h0003_0000);
    rd(4, d); chk("R6 levels cleared", d, 0);
    rd(5, d); chk("R6 rx pointers", d, 0);
    rd(6, d); chk("R6 tx pointers", d, 0);
  endtask

  task automatic t_underflow;
    logic [31:0] d;
    wr(1, 32'h3f); tx_req = 1; step; tx_req = 0;
    rd(1, d); chk("R11 underflow flag", d, 32'h20);
    wr(1, 32'h3f);
  endtask

  task automatic t_tx_wm;
    logic [31:0] d;
    wr(3, 32'h0080_0080); wr(6, 32'h80 << 16);
    rd(4, d); chk("R10 tx level", d[31:16], 32'h80);
    rd(1, d); chk("R10 no flag yet", d, 0);
    tx_req = 1; step; tx_req = 0;
    rd(1, d); chk("R10 tx watermark flag", d, 32'h04);
    wr(0, EN | 32'h0002_0000); wr(1, 32'h3f);
  endtask

  task automatic t_rx_fill;
    logic [31:0] d;
    wr(2, 32'h37);
    for (int i = 0; i < 128; i++) send(i[7:0]);
    rd(1, d); chk("R9 rx watermark not yet", d, 0);
    send(8'd128);
    rd(1, d); chk("R9 rx watermark flag", d, 32'h02);
    chk("R12 irq masked view", {26'd0, irq}, 32'h02);
    for (int i = 129; i < 2047; i++) send(i[7:0]);
    rd(1, d); chk("R7 no full at 2047", d[0], 0);
    send(8'h77);
    rd(1, d); chk("R7 full flag", d[0], 1);
    send(8'h99);
    rd(1, d); chk("R8 overflow flag", d, 32'h13);
    rd(5, d); chk("R8 pointer held", d, {16'd2048, 16'd0});
    buf_addr = 2047; #1 chk("R8 last byte kept", {24'd0, buf_rdata}, 32'h77);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    chk("R12 irq", {26'd0, irq}, 32'h13);
    wr(2, 0); chk("R12 masked irq", {26'd0, irq}, 0);
    rd(1, d); chk("R12 sticky", d, 32'h13);
    wr(1, 32'h11); rd(1, d); chk("R12 partial clear", d, 32'h02);
    wr(1, 32'h02); rd(1, d); chk("R12 cleared", d, 0);
    wr(0, EN | 32'h0001_0000);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(8, {16'd598, 16'd600}); wr(0, EN | 32'h0002_0000);
    for (int i = 0; i < 8; i++) bw(12'(2400 + i), 8'(8'h10 + i));
    wr(6, 32'd8 << 16);
    rd(4, d); chk("R2 small window level", d[31:16], 32'd8);
    for (int i = 0; i < 8; i++) pop("R2 window byte", 8'(8'h10 + i));
    bw(2400, 8'h20); bw(2401, 8'h21); bw(2402, 8'h22);
    wr(6, 32'd11 << 16);
    rd(4, d); chk("R2 level after wrap", d[31:16], 32'd3);
    pop("R2 wrapped byte0", 8'h20); pop("R2 wrapped byte1", 8'h21);
    pop("R2 wrapped byte2", 8'h22);
  endtask

  initial begin
    repeat (2) step;
    rst_n = 1; step;
    t_reset; t_gating; t_rx_basic; t_tx_basic; t_clear;
    t_underflow; t_tx_wm; t_rx_fill; t_w1c; t_wrap;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule